// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide programming interface of an 8259-style interrupt controller. A host issues writes and reads through one strobe pair, one address bit and an 8-bit data bus. Writes are decoded into the four-step initialization sequence and the three operation commands. Reads return the request, in-service or mask register, or a poll answer. The block keeps the configuration that the priority logic uses: vector base, mask, auto end-of-interrupt, special fully nested, special mask, poll and read-select. It also passes single-cycle commands to that logic. Edge capture and priority resolution are outside the block. The request and in-service registers and the winning pin come in as inputs.

Only the cascaded, four-word, 8086-mode configuration is accepted. A parameter chooses between master and slave, and the special fully nested bit is kept only on a master.

Top module: `icu_cmd_port`

## Requirements
- R1: While reset is low, and after it, `imr` is 0xFF. `err`, `ready`, `poll`, `smm`, `rd_isr_sel`, `auto_eoi`, `sfn`, `vec_base`, `rdata` and all strobes are 0.
- R2: A write with `a0`=0 and data bit 4 set is the first init word. It pulses `init_pulse` and clears `imr`, `smm`, `poll`, `rd_isr_sel` and `ready`.
- R3: If that first word has bit 1 set (single mode) or bit 0 clear (no fourth word), `err` is set and the sequence stays idle. A following `a0`=1 write then loads `imr`.
- R4: After a good first word, the next `a0`=1 write sets `vec_base` to data AND 0xF8. The one after that (the third word) changes no output.
- R5: The fourth `a0`=1 write sets `err` and waits for another fourth word if data bit 0 is clear. Otherwise it sets `auto_eoi` from bit 1 and sets `sfn` from bit 4 on a master only (always 0 on a slave), then raises `ready`.
- R6: When no init word is pending, an `a0`=1 write loads `imr` with the data.
- R7: With `ready` high, an `a0`=0 write with bits 4 and 3 clear pulses `ocw2_stb` and puts the byte on `ocw2_cmd`. When `ready` is low, such a write has no effect.
- R8: With `ready` high, an `a0`=0 write with bit 3 set and bit 4 clear works as follows. Bit 6 set loads `smm` from bit 5. Bit 1 set loads `rd_isr_sel` from bit 0 and `poll` from bit 2. Fields whose enable bit is clear keep their value.
- R9: A read with `poll` set clears `poll`. If `poll_hit` is set, it returns 0x80 OR `poll_pin` and pulses `accept_stb` with `accept_pin`=`poll_pin`. Otherwise it returns 0.
- R10: A read without poll returns `imr` when `a0`=1. When `a0`=0 it returns `isr_i` if `rd_isr_sel` is set, otherwise `irr_i`.
- R11: Every result appears on the clock edge that samples the strobe. `err` shows the result of the latest write. A read in the same cycle as a write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| a0 | input | 1 | Address bit |
| wdata | input | 8 | Write data |
| irr_i | input | 8 | Request register from priority logic |
| isr_i | input | 8 | In-service register from priority logic |
| poll_hit | input | 1 | An eligible pin exists |
| poll_pin | input | 3 | Winning eligible pin |
| rdata | output | 8 | Read data, held until next read |
| err | output | 1 | Latest write was rejected |
| ready | output | 1 | Initialization complete |
| vec_base | output | 8 | Vector base (low 3 bits zero) |
| imr | output | 8 | Interrupt mask |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| sfn | output | 1 | Special fully nested mode |
| smm | output | 1 | Special mask mode |
| poll | output | 1 | Poll armed for next read |
| rd_isr_sel | output | 1 | Non-poll `a0`=0 read returns in-service |
| init_pulse | output | 1 | One-cycle: clear requests, reset rotation |
| ocw2_stb | output | 1 | One-cycle: end-of-interrupt/rotation command |
| ocw2_cmd | output | 8 | Last forwarded command byte |
| accept_stb | output | 1 | One-cycle: pin accepted by poll read |
| accept_pin | output | 3 | Pin of last poll accept |

## Verification
Each output is a register. A write or read driven before a rising edge therefore shows its full effect on the outputs at the falling edge that follows, and each strobe pulse lasts exactly that one cycle. The bench steps a behavioural model on the same rising edge and compares every output of a master and a slave instance at each falling edge. A missing or extra cycle of latency thus fails at once. The directed phases each tag their own requirement, and a long mixed-traffic phase covers orderings.

// File: rtl/icu_cmd_port.sv
module icu_cmd_port #(
  parameter bit MASTER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       a0,
  input  logic [7:0] wdata,
  input  logic [7:0] irr_i,
  input  logic [7:0] isr_i,
  input  logic       poll_hit,
  input  logic [2:0] poll_pin,
  output logic [7:0] rdata,
  output logic       err,
  output logic       ready,
  output logic [7:0] vec_base,
  output logic [7:0] imr,
  output logic       auto_eoi,
  output logic       sfn,
  output logic       smm,
  output logic       poll,
  output logic       rd_isr_sel,
  output logic       init_pulse,
  output logic       ocw2_stb,
  output logic [7:0] ocw2_cmd,
  output logic       accept_stb,
  output logic [2:0] accept_pin
);
  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_VEC  = 2'd1;
  localparam logic [1:0] ST_CASC = 2'd2;
  localparam logic [1:0] ST_MODE = 2'd3;

  logic [1:0] stage;
  logic       rd_go;
  logic       is_init1, is_op3, is_op2, first_bad;

  assign rd_go     = rd_en && !wr_en;
  assign is_init1  = !a0 && wdata[4];
  assign is_op3    = !a0 && !wdata[4] && wdata[3] && ready;
  assign is_op2    = !a0 && !wdata[4] && !wdata[3] && ready;
  assign first_bad = wdata[1] || !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= ST_RUN;
      rdata      <= '0;
      err        <= 1'b0;
      ready      <= 1'b0;
      vec_base   <= '0;
      imr        <= 8'hFF;
      auto_eoi   <= 1'b0;
      sfn        <= 1'b0;
      smm        <= 1'b0;
      poll       <= 1'b0;
      rd_isr_sel <= 1'b0;
      init_pulse <= 1'b0;
      ocw2_stb   <= 1'b0;
      ocw2_cmd   <= '0;
      accept_stb <= 1'b0;
      accept_pin <= '0;
    end else begin
      init_pulse <= 1'b0;
      ocw2_stb   <= 1'b0;
      accept_stb <= 1'b0;
      if (rd_go) begin
        if (poll) begin
          poll <= 1'b0;
          if (poll_hit) begin
            rdata      <= {5'b10000, poll_pin};
            accept_stb <= 1'b1;
            accept_pin <= poll_pin;
          end else begin
            rdata <= '0;
          end
        end else if (a0) begin
          rdata <= imr;
        end else begin
          rdata <= rd_isr_sel ? isr_i : irr_i;
        end
      end
      if (wr_en) begin
        err <= 1'b0;
        if (is_init1) begin
          init_pulse <= 1'b1;
          imr        <= '0;
          smm        <= 1'b0;
          poll       <= 1'b0;
          rd_isr_sel <= 1'b0;
          ready      <= 1'b0;
          err        <= first_bad;
          stage      <= first_bad ? ST_RUN : ST_VEC;
        end else if (is_op3) begin
          if (wdata[6]) smm <= wdata[5];
          if (wdata[1]) begin
            rd_isr_sel <= wdata[0];
            poll       <= wdata[2];
          end
        end else if (is_op2) begin
          ocw2_stb <= 1'b1;
          ocw2_cmd <= wdata;
        end else if (a0) begin
          case (stage)
            ST_VEC: begin
              vec_base <= wdata & 8'hF8;
              stage    <= ST_CASC;
            end
            ST_CASC: stage <= ST_MODE;
            ST_MODE: begin
              if (!wdata[0]) begin
                err <= 1'b1;
              end else begin
                auto_eoi <= wdata[1];
                sfn      <= MASTER & wdata[4];
                ready    <= 1'b1;
                stage    <= ST_RUN;
              end
            end
            default: imr <= wdata;
          endcase
        end
      end
    end
  end
endmodule

module icu_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       a0,
  input logic [7:0] wdata,
  input logic [7:0] imr,
  input logic [7:0] rdata,
  input logic [7:0] vec_base,
  input logic       ready,
  input logic       poll,
  input logic       init_pulse,
  input logic       ocw2_stb,
  input logic       accept_stb
);
  a_r1_reset_mask: assert property (@(posedge clk)
    !rst_n |=> (imr == 8'hFF && !ready && !poll));
  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !a0 && wdata[4]) |=> (init_pulse && imr == 8'h00 && !ready && !poll));
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a0 && ready) |=> (imr == $past(wdata)));
  a_r7_cmd_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ocw2_stb |-> $past(ready));
  a_r9_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && poll) |=> !poll);
  a_r9_accept_flag: assert property (@(posedge clk) disable iff (!rst_n)
    accept_stb |-> rdata[7]);
  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    vec_base[2:0] == 3'b000);
endmodule

bind icu_cmd_port icu_cmd_port_chk chk_i (.*);

// File: tb/icu_cmd_port_tb_top.sv
`timescale 1ns/1ps
module icu_cmd_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, a0 = 1'b0;
  logic [7:0] wdata = '0, irr_i = '0, isr_i = '0;
  logic poll_hit = 1'b0;
  logic [2:0] poll_pin = '0;

  always #2.5 clk = ~clk;

  logic [44:0] mo, so;
  logic [7:0] m_rdata, s_rdata, m_vb, s_vb, m_imr, s_imr, m_cmd, s_cmd;
  logic m_err, s_err, m_rdy, s_rdy, m_ae, s_ae, m_sfn, s_sfn, m_smm, s_smm;
  logic m_poll, s_poll, m_ris, s_ris, m_ip, s_ip, m_o2, s_o2, m_acc, s_acc;
  logic [2:0] m_ap, s_ap;

  icu_cmd_port #(.MASTER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0), .wdata(wdata),
    .irr_i(irr_i), .isr_i(isr_i), .poll_hit(poll_hit), .poll_pin(poll_pin),
    .rdata(m_rdata), .err(m_err), .ready(m_rdy), .vec_base(m_vb), .imr(m_imr),
    .auto_eoi(m_ae), .sfn(m_sfn), .smm(m_smm), .poll(m_poll), .rd_isr_sel(m_ris),
    .init_pulse(m_ip), .ocw2_stb(m_o2), .ocw2_cmd(m_cmd), .accept_stb(m_acc), .accept_pin(m_ap));
  icu_cmd_port #(.MASTER(1'b0)) slv_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0), .wdata(wdata),
    .irr_i(irr_i), .isr_i(isr_i), .poll_hit(poll_hit), .poll_pin(poll_pin),
    .rdata(s_rdata), .err(s_err), .ready(s_rdy), .vec_base(s_vb), .imr(s_imr),
    .auto_eoi(s_ae), .sfn(s_sfn), .smm(s_smm), .poll(s_poll), .rd_isr_sel(s_ris),
    .init_pulse(s_ip), .ocw2_stb(s_o2), .ocw2_cmd(s_cmd), .accept_stb(s_acc), .accept_pin(s_ap));

  assign mo = {m_rdata, m_err, m_rdy, m_vb, m_imr, m_ae, m_sfn, m_smm, m_poll, m_ris, m_ip, m_o2, m_cmd, m_acc, m_ap};
  assign so = {s_rdata, s_err, s_rdy, s_vb, s_imr, s_ae, s_sfn, s_smm, s_poll, s_ris, s_ip, s_o2, s_cmd, s_acc, s_ap};

  // behavioural model
  int  e_stage;
  logic [7:0] e_rdata, e_vb, e_imr, e_cmd;
  logic e_err, e_rdy, e_ae, e_sfn, e_smm, e_poll, e_ris, e_ip, e_o2, e_acc;
  logic [2:0] e_ap;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_stage = 0; e_rdata = 0; e_err = 0; e_rdy = 0; e_vb = 0; e_imr = 8'hFF;
      e_ae = 0; e_sfn = 0; e_smm = 0; e_poll = 0; e_ris = 0; e_ip = 0; e_o2 = 0;
      e_cmd = 0; e_acc = 0; e_ap = 0;
    end else begin
      e_ip = 0; e_o2 = 0; e_acc = 0;
      if (rd_en && !wr_en) begin
        if (e_poll) begin
          e_poll = 0;
          if (poll_hit) begin e_rdata = 8'h80 + 8'(poll_pin); e_acc = 1; e_ap = poll_pin; end
          else e_rdata = 0;
        end else e_rdata = a0 ? e_imr : (e_ris ? isr_i : irr_i);
      end
      if (wr_en) begin
        e_err = 0;
        if (!a0 && wdata[4]) begin
          e_ip = 1; e_imr = 0; e_smm = 0; e_poll = 0; e_ris = 0; e_rdy = 0;
          if (wdata[1] == 1'b1 || wdata[0] == 1'b0) begin e_err = 1; e_stage = 0; end
          else e_stage = 1;
        end else if (!a0) begin
          if (e_rdy && wdata[3]) begin
            if (wdata[6]) e_smm = wdata[5];
            if (wdata[1]) begin e_ris = wdata[0]; e_poll = wdata[2]; end
          end else if (e_rdy) begin e_o2 = 1; e_cmd = wdata; end
        end else if (e_stage == 1) begin e_vb = {wdata[7:3], 3'b000}; e_stage = 2; end
        else if (e_stage == 2) e_stage = 3;
        else if (e_stage == 3) begin
          if (!wdata[0]) e_err = 1;
          else begin e_ae = wdata[1]; e_sfn = wdata[4]; e_rdy = 1; e_stage = 0; end
        end else e_imr = wdata;
      end
    end
  end

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always @(negedge clk) begin
    logic [44:0] em, es;
    em = {e_rdata, e_err, e_rdy, e_vb, e_imr, e_ae, e_sfn, e_smm, e_poll, e_ris, e_ip, e_o2, e_cmd, e_acc, e_ap};
    es = {e_rdata, e_err, e_rdy, e_vb, e_imr, e_ae, 1'b0, e_smm, e_poll, e_ris, e_ip, e_o2, e_cmd, e_acc, e_ap};
    if (!done) begin
      checks += 2;
      if (mo !== em) begin errors++; $display("FAIL %s master: actual %h expected %h", cur_req, mo, em); end
      if (so !== es) begin errors++; $display("FAIL %s slave: actual %h expected %h", cur_req, so, es); end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); #1; wr_en = 1; a0 = a; wdata = d;
    @(negedge clk); #1; wr_en = 0;
  endtask
  task automatic rd(input logic a);
    @(negedge clk); #1; rd_en = 1; a0 = a;
    @(negedge clk); #1; rd_en = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    rd(1'b1);
    cur_req = "R3";
    wr(1'b0, 8'h13);           // single mode: rejected
    wr(1'b1, 8'h5A);           // mask load
    wr(1'b0, 8'h10);           // no fourth word: rejected
    cur_req = "R2";
    wr(1'b0, 8'h11);
    cur_req = "R7";
    wr(1'b0, 8'h20);           // not ready: ignored
    cur_req = "R4";
    wr(1'b1, 8'h6B);
    wr(1'b1, 8'h04);
    cur_req = "R5";
    wr(1'b1, 8'h02);           // no 8086 bit: rejected
    wr(1'b1, 8'h13);
    cur_req = "R6";
    wr(1'b1, 8'hC3);
    rd(1'b1);
    cur_req = "R7";
    wr(1'b0, 8'h65);
    cur_req = "R8";
    irr_i = 8'h3C; isr_i = 8'h81;
    wr(1'b0, 8'h6B);
    cur_req = "R10";
    rd(1'b0);
    cur_req = "R8";
    wr(1'b0, 8'h0A);
    wr(1'b0, 8'h28);           // no enables: nothing changes
    cur_req = "R10";
    rd(1'b0);
    cur_req = "R9";
    poll_hit = 1; poll_pin = 3'd5;
    wr(1'b0, 8'h0E);
    rd(1'b0);
    poll_hit = 0;
    wr(1'b0, 8'h0E);
    rd(1'b0);
    wr(1'b0, 8'h48);
    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      irr_i = 8'($urandom); isr_i = 8'($urandom);
      poll_hit = 1'($urandom); poll_pin = 3'($urandom);
      a0 = 1'($urandom);
      wdata = 8'($urandom);
      case ($urandom % 5)
        0: begin wr_en = 1; rd_en = 0; end
        1: begin wr_en = 0; rd_en = 1; end
        2: begin wr_en = 1; rd_en = 1; end
        default: begin wr_en = 0; rd_en = 0; end
      endcase
      if (wr_en && ($urandom % 4 == 0)) wdata = 8'h11;
    end
    @(negedge clk); #1; wr_en = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule